// File: doc/BRIEF.md
# UART Interrupt Source, Mask and Pending Combiner

This block gathers the four interrupt causes of one serial port into a set of sticky source flags. It holds a per-source mask and presents the unmasked flags as a pending vector. A single level-sensitive interrupt line is raised whenever any pending flag is set. Each cause arrives as a one-cycle set pulse from the surrounding port logic. Software acknowledges causes through a small write port that addresses the source, pending and mask registers.

The transmit cause has a second, level-driven origin. While the FIFO is enabled and the number of bytes waiting to be sent is at or below a threshold, the transmit flag is set again on every clock. The threshold is a 3-bit trigger field multiplied by a step fixed per port instance through the `CHANNEL` parameter.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the source flags and the mask are all zero, pending is zero and `irq` is low.
- R2: Set pulses land in fixed source bits: receive in bit 0, error in bit 1, transmit byte written in bit 2, modem in bit 3. Each is visible from the clock edge that samples the pulse.
- R3: `pend` always equals source AND NOT mask, and `irq` is high exactly when `pend` is non-zero.
- R4: A write with `wr_sel` = 1 (pending register) clears every source bit whose `wr_data` bit is 1, and so also clears those pending bits.
- R5: A write with `wr_sel` = 0 (source register) is write-1-to-clear on the source flags. Zero bits leave flags unchanged.
- R6: A write with `wr_sel` = 2 replaces the mask with `wr_data`, and `pend`/`irq` follow the new mask from that edge on.
- R7: The transmit threshold is `tx_trig` times a step of 32 for channel 0, 8 for channels 1 and 4, and 2 for channels 2 and 3. When `fifo_en` is 1 and `tx_count` is at or below the threshold, source bit 2 is set at the clock edge.
- R8: With `fifo_en` at 0, the transmit count and trigger field never set source bit 2.
- R9: Any other channel number gives a threshold of 0, so only an empty transmit FIFO sets bit 2.
- R10: When a set (pulse or transmit level) and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R11: A write with `wr_sel` = 3 changes neither the source flags nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| set_rx | input | 1 | Receive cause pulse |
| set_err | input | 1 | Error cause pulse |
| set_txb | input | 1 | Transmit byte written pulse |
| set_modem | input | 1 | Modem cause pulse |
| fifo_en | input | 1 | FIFO mode enable |
| tx_trig | input | 3 | Transmit trigger-level field |
| tx_count | input | CNT_W | Bytes held in the transmit FIFO |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 source, 1 pending, 2 mask, 3 reserved |
| wr_data | input | 4 | Write data, one bit per source |
| src_flags | output | 4 | Sticky source flags |
| mask_q | output | 4 | Current mask |
| pend | output | 4 | Unmasked pending flags |
| irq | output | 1 | Level interrupt request |

## Verification
Set pulses are applied one source at a time. This shows that each cause lands in its own bit and that masking one cause hides it without disturbing the others. Clears are issued through the pending register and the source register with differing bit patterns. These show which bits each write removes and that the reserved select changes nothing. The transmit level path is driven with counts exactly at and one above the threshold on three instances with different channel numbers. This separates the step values and the invalid-channel case, and a same-cycle set and clear shows that the set has priority.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int CHANNEL = 0,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_rx,
  input  logic             set_err,
  input  logic             set_txb,
  input  logic             set_modem,
  input  logic             fifo_en,
  input  logic [2:0]       tx_trig,
  input  logic [CNT_W-1:0] tx_count,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [3:0]       wr_data,
  output logic [3:0]       src_flags,
  output logic [3:0]       mask_q,
  output logic [3:0]       pend,
  output logic             irq
);

  localparam int STEP  = (CHANNEL == 0) ? 32 :
                         (CHANNEL == 1 || CHANNEL == 4) ? 8 :
                         (CHANNEL == 2 || CHANNEL == 3) ? 2 : 0;
  localparam int THR_W = CNT_W + 6;

  localparam logic [1:0] SEL_SRC  = 2'd0;
  localparam logic [1:0] SEL_PEND = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;

  logic [THR_W-1:0] thr;
  logic             tx_level;
  logic [3:0]       set_vec;
  logic [3:0]       clr_vec;
  logic [3:0]       src_q;
  logic [3:0]       msk_q;

  assign thr      = THR_W'(tx_trig) * THR_W'(STEP);
  assign tx_level = fifo_en && (THR_W'(tx_count) <= thr);
  assign set_vec  = {set_modem, set_txb | tx_level, set_err, set_rx};
  assign clr_vec  = (wr_en && (wr_sel == SEL_SRC || wr_sel == SEL_PEND)) ? wr_data : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= 4'b0;
      msk_q <= 4'b0;
    end else begin
      src_q <= (src_q & ~clr_vec) | set_vec;
      if (wr_en && wr_sel == SEL_MASK)
        msk_q <= wr_data;
    end
  end

  assign src_flags = src_q;
  assign mask_q    = msk_q;
  assign pend      = src_q & ~msk_q;
  assign irq       = |pend;

  // R2 R10
  src_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((src_q & $past(set_vec)) == $past(set_vec)));

  // R4 R5
  src_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_vec & ~set_vec)) |=> ((src_q & $past(clr_vec & ~set_vec)) == 4'b0));

  // R6
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_MASK) |=> (msk_q == $past(wr_data)));

  // R3
  irq_unmasked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(set_vec & ~msk_q)) && !(wr_en && wr_sel == SEL_MASK)) |=> irq);

  // R7
  tx_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && (THR_W'(tx_count) <= thr)) |=> src_q[2]);

  // R11
  no_spurious_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((src_q & ~$past(src_q) & ~$past(set_vec)) == 4'b0));

endmodule

// File: tb/uart_irq_ctrl_tb.sv
`timescale 1ns/1ps
module uart_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_rx = 0, set_err = 0, set_txb = 0, set_modem = 0;
  logic fifo_en = 0;
  logic [2:0] tx_trig = 0;
  logic [7:0] tx_count = 0;
  logic wr_en = 0;
  logic [1:0] wr_sel = 0;
  logic [3:0] wr_data = 0;
  logic [3:0] src0, msk0, pnd0, src2, msk2, pnd2, src7, msk7, pnd7;
  logic irq0, irq2, irq7;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_irq_ctrl #(.CHANNEL(0), .CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .set_rx(set_rx), .set_err(set_err), .set_txb(set_txb),
    .set_modem(set_modem), .fifo_en(fifo_en), .tx_trig(tx_trig), .tx_count(tx_count),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .src_flags(src0), .mask_q(msk0), .pend(pnd0), .irq(irq0));
  uart_irq_ctrl #(.CHANNEL(2), .CNT_W(8)) u_dut_c2 (
    .clk(clk), .rst_n(rst_n), .set_rx(set_rx), .set_err(set_err), .set_txb(set_txb),
    .set_modem(set_modem), .fifo_en(fifo_en), .tx_trig(tx_trig), .tx_count(tx_count),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .src_flags(src2), .mask_q(msk2), .pend(pnd2), .irq(irq2));
  uart_irq_ctrl #(.CHANNEL(7), .CNT_W(8)) u_dut_c7 (
    .clk(clk), .rst_n(rst_n), .set_rx(set_rx), .set_err(set_err), .set_txb(set_txb),
    .set_modem(set_modem), .fifo_en(fifo_en), .tx_trig(tx_trig), .tx_count(tx_count),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .src_flags(src7), .mask_q(msk7), .pend(pnd7), .irq(irq7));

  // {set[3:0], wr_en, wr_sel, wr_data, fifo_en, trig, count, exp_src, exp_msk, exp_irq}
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV] = '{
    {4'b0001, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0,   4'b0001, 4'b0000, 1'b1}, // R2 rx
    {4'b0010, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0,   4'b0011, 4'b0000, 1'b1}, // R2 err
    {4'b1000, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0,   4'b1011, 4'b0000, 1'b1}, // R2 modem
    {4'b0000, 1'b1, 2'd2, 4'hb, 1'b0, 3'd0, 8'd0,   4'b1011, 4'b1011, 1'b0}, // R6
    {4'b0100, 1'b0, 2'd0, 4'h0, 1'b0, 3'd0, 8'd0,   4'b1111, 4'b1011, 1'b1}, // R2 tx byte R9-like
    {4'b0000, 1'b1, 2'd1, 4'h4, 1'b0, 3'd0, 8'd0,   4'b1011, 4'b1011, 1'b0}, // R4
    {4'b0000, 1'b1, 2'd0, 4'h3, 1'b0, 3'd0, 8'd0,   4'b1000, 4'b1011, 1'b0}, // R5
    {4'b0000, 1'b1, 2'd2, 4'h0, 1'b0, 3'd0, 8'd0,   4'b1000, 4'b0000, 1'b1}, // R6 R3
    {4'b0000, 1'b1, 2'd3, 4'hf, 1'b0, 3'd0, 8'd0,   4'b1000, 4'b0000, 1'b1}, // R11
    {4'b1000, 1'b1, 2'd0, 4'h8, 1'b0, 3'd0, 8'd0,   4'b1000, 4'b0000, 1'b1}, // R10
    {4'b0000, 1'b1, 2'd0, 4'h8, 1'b0, 3'd0, 8'd0,   4'b0000, 4'b0000, 1'b0}, // R5
    {4'b0000, 1'b0, 2'd0, 4'h0, 1'b1, 3'd1, 8'd32,  4'b0100, 4'b0000, 1'b1}, // R7 at threshold
    {4'b0000, 1'b1, 2'd1, 4'h4, 1'b1, 3'd1, 8'd33,  4'b0000, 4'b0000, 1'b0}, // R7 above
    {4'b0000, 1'b0, 2'd0, 4'h0, 1'b1, 3'd7, 8'd224, 4'b0100, 4'b0000, 1'b1}, // R7 max
    {4'b0000, 1'b1, 2'd0, 4'h4, 1'b0, 3'd0, 8'd0,   4'b0000, 4'b0000, 1'b0}, // R8
    {4'b0000, 1'b0, 2'd0, 4'h0, 1'b0, 3'd7, 8'd0,   4'b0000, 4'b0000, 1'b0}, // R8
    {4'b0000, 1'b1, 2'd1, 4'h4, 1'b1, 3'd0, 8'd0,   4'b0100, 4'b0000, 1'b1}, // R10 level vs clear
    {4'b0000, 1'b1, 2'd1, 4'hf, 1'b1, 3'd0, 8'd1,   4'b0000, 4'b0000, 1'b0}  // R4 R7
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk);
    {set_modem, set_txb, set_err, set_rx} = v[31:28];
    wr_en = v[27]; wr_sel = v[26:25]; wr_data = v[24:21];
    fifo_en = v[20]; tx_trig = v[19:17]; tx_count = v[16:9];
    @(posedge clk); #1;
  endtask

  task automatic idle();
    drive(32'h0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #12;
    check("R1 src", src0, 4'b0);
    check("R1 mask", msk0, 4'b0);
    check("R1 irq", {3'b0, irq0}, 4'b0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] v;
      v = VEC[i];
      drive(v);
      check($sformatf("R2/R4/R5/R7 src row %0d", i), src0, v[8:5]);
      check($sformatf("R6 mask row %0d", i), msk0, v[4:1]);
      check($sformatf("R3 pend row %0d", i), pnd0, v[8:5] & ~v[4:1]);
      check($sformatf("R3 irq row %0d", i), {3'b0, irq0}, {3'b0, v[0]});
    end

    // R7/R9 channel steps: trig 3, count 7 -> thr 96 / 6 / 0
    drive({4'b0, 1'b1, 2'd0, 4'hf, 1'b1, 3'd3, 8'd7, 9'd0});
    check("R7 ch0 count7", src0, 4'b0100);
    check("R7 ch2 count7", src2, 4'b0000);
    check("R9 ch7 count7", src7, 4'b0000);
    drive({4'b0, 1'b1, 2'd0, 4'hf, 1'b1, 3'd3, 8'd6, 9'd0});
    check("R7 ch2 count6", src2, 4'b0100);
    check("R9 ch7 count6", src7, 4'b0000);
    drive({4'b0, 1'b1, 2'd0, 4'hf, 1'b1, 3'd7, 8'd1, 9'd0});
    check("R9 ch7 count1", src7, 4'b0000);
    drive({4'b0, 1'b0, 2'd0, 4'h0, 1'b1, 3'd7, 8'd0, 9'd0});
    check("R9 ch7 count0", src7, 4'b0100);
    drive({4'b0, 1'b1, 2'd0, 4'hf, 1'b0, 3'd0, 8'd0, 9'd0});
    check("R5 clear all", src0 | src2 | src7, 4'b0000);

    // R2 tx byte pulse with FIFO off; R1 reset mid-run
    drive({4'b0100, 1'b1, 2'd2, 4'h1, 1'b0, 3'd0, 8'd0, 9'd0});
    check("R2 txb", src0, 4'b0100);
    idle();
    @(negedge clk); rst_n = 1'b0;
    #1;
    check("R1 mid src", src0, 4'b0);
    check("R1 mid mask", msk0, 4'b0);
    check("R1 mid irq", {3'b0, irq0}, 4'b0);
    @(negedge clk); rst_n = 1'b1;
    idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule